// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block sequences zero-overhead loops for a processor's fetch stage. A loop-start command supplies an iteration count, the address of the first body instruction and a loop end address. The end address names the first instruction after the body, so the body's last instruction is at the end address minus one. The controller pushes this context onto a small internal stack, which lets loops nest. An inner loop of count N2 inside an outer loop of count N1 runs its body N1*N2 times.

The controller watches every valid fetch address. When fetch reaches the last body instruction of the innermost loop and iterations remain, it asserts a redirect in the same cycle that sends the next fetch back to the body start, and it decrements the count. On the final iteration it lets fetch fall through to the end address and pops the level, which restores the enclosing loop. A zero count skips the body by redirecting straight to the end address. An abort input drops the innermost level at once without redirecting, which supports early exits. A loop-active flag is high while any level is on the stack.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset, loop_active_o is 0, no redirect is issued and overflow_o is 0. While no loop is active and no start is presented, redirect_o stays 0.
- R2: A start with a non-zero count pushes a level, and loop_active_o reads 1 from the next cycle on.
- R3: A valid fetch at (end address - 1) of the innermost level whose remaining count is above 1 asserts redirect_o in the same cycle with redirect_pc_o equal to that level's body start address, and it decrements the count.
- R4: A valid fetch at (end address - 1) with remaining count 1 gives no redirect and pops the level. loop_active_o drops only when the stack becomes empty.
- R5: Nested levels multiply. An inner loop of count N2 inside an outer loop of count N1 runs N1*N2 inner body passes and N1 outer passes.
- R6: A start with count 0 asserts redirect_o in the same cycle with redirect_pc_o equal to the start's end address, and it pushes nothing.
- R7: A start with a non-zero count while DEPTH levels are held asserts overflow_o for that cycle and leaves the stack unchanged.
- R8: abort_i pops the innermost level in that cycle and suppresses any redirect, even when fetch is at that level's last body address.
- R9: A fetch is compared only when fetch_valid_i is 1. Addresses other than (end address - 1) of the innermost level cause no redirect and no count change.
- R10: Priority per cycle is abort, then start, then fetch matching. A start presented with abort_i is ignored, and no fetch match is acted on in a cycle that carries a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Loop-start command |
| start_cnt_i | input | CW | Iteration count of the new loop |
| start_body_i | input | AW | Address of the first body instruction |
| start_end_i | input | AW | Address of the first instruction after the body |
| fetch_valid_i | input | 1 | fetch_pc_i holds a real fetch |
| fetch_pc_i | input | AW | Current fetch address |
| abort_i | input | 1 | Drop innermost loop level now |
| redirect_o | output | 1 | Next fetch must come from redirect_pc_o |
| redirect_pc_o | output | AW | Redirect target |
| loop_active_o | output | 1 | At least one loop level is held |
| overflow_o | output | 1 | Start refused because the stack is full |

## Verification
Every cycle, the assertions check the following: stack depth moves by exactly one on an accepted start or an abort, it stays put on a refused or zero-count start, it never exceeds DEPTH, and the idle and abort cycles never redirect. The target and timing of loop-back redirects, the fall-through on the last pass, the multiplied counts of nested loops and the effect of fetch_valid_i only show up in the bench's instruction-address sequences. The same holds for the flag staying high after an inner pop and for the ordering of abort over start.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
    parameter int unsigned HWL_AW = 16;
    parameter int unsigned HWL_CW = 16;

    typedef struct packed {
        logic [HWL_AW-1:0] body;
        logic [HWL_AW-1:0] stop;
        logic [HWL_CW-1:0] cnt;
    } frame_t;
endpackage

// File: rtl/hwl_stack.sv
module hwl_stack
    import hwl_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned LW = $clog2(DEPTH + 1),
    localparam int unsigned IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  frame_t        push_frame_i,
    input  logic          pop_i,
    input  logic          dec_i,
    output frame_t        top_o,
    output logic [LW-1:0] level_o,
    output logic          empty_o,
    output logic          full_o
);
    typedef struct {
        frame_t        mem [DEPTH];
        logic [LW-1:0] lvl;
    } stk_t;

    stk_t          st_d, st_q;
    logic [IW-1:0] top_idx, push_idx;

    always_comb begin
        st_d     = st_q;
        top_idx  = IW'(st_q.lvl - LW'(1));
        push_idx = IW'(st_q.lvl);
        if (pop_i && st_q.lvl != '0) begin
            st_d.lvl = st_q.lvl - LW'(1);
        end else if (push_i && st_q.lvl != LW'(DEPTH)) begin
            st_d.mem[push_idx] = push_frame_i;
            st_d.lvl           = st_q.lvl + LW'(1);
        end else if (dec_i && st_q.lvl != '0) begin
            st_d.mem[top_idx].cnt = st_q.mem[top_idx].cnt - HWL_CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                st_q.mem[i] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign top_o   = st_q.mem[top_idx];
    assign level_o = st_q.lvl;
    assign empty_o = (st_q.lvl == '0);
    assign full_o  = (st_q.lvl == LW'(DEPTH));
endmodule

// File: rtl/hwl_match.sv
module hwl_match
    import hwl_pkg::*;
(
    input  logic              armed_i,
    input  logic              fetch_valid_i,
    input  logic [HWL_AW-1:0] fetch_pc_i,
    input  frame_t            frame_i,
    output logic              hit_o,
    output logic              last_o
);
    logic [HWL_AW-1:0] tail_pc;

    always_comb begin
        tail_pc = frame_i.stop - HWL_AW'(1);
        hit_o   = armed_i && fetch_valid_i && (fetch_pc_i == tail_pc);
        last_o  = (frame_i.cnt == HWL_CW'(1));
    end
endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl
    import hwl_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW = HWL_AW,
    localparam int unsigned CW = HWL_CW,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] start_cnt_i,
    input  logic [AW-1:0] start_body_i,
    input  logic [AW-1:0] start_end_i,
    input  logic          fetch_valid_i,
    input  logic [AW-1:0] fetch_pc_i,
    input  logic          abort_i,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o,
    output logic          loop_active_o,
    output logic          overflow_o
);
    typedef struct packed {
        logic          push;
        logic          pop;
        logic          dec;
        logic          redir;
        logic [AW-1:0] target;
        logic          ovf;
    } ctl_t;

    ctl_t          ctl;
    frame_t        top, new_frame;
    logic [LW-1:0] level;
    logic          empty, full, hit, last;

    hwl_stack #(.DEPTH(DEPTH)) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (ctl.push),
        .push_frame_i (new_frame),
        .pop_i        (ctl.pop),
        .dec_i        (ctl.dec),
        .top_o        (top),
        .level_o      (level),
        .empty_o      (empty),
        .full_o       (full)
    );

    hwl_match u_match (
        .armed_i       (!empty),
        .fetch_valid_i (fetch_valid_i),
        .fetch_pc_i    (fetch_pc_i),
        .frame_i       (top),
        .hit_o         (hit),
        .last_o        (last)
    );

    always_comb begin
        logic zero_cnt;
        logic take_start;
        logic take_match;
        zero_cnt   = (start_cnt_i == '0);
        take_start = start_i && !abort_i;
        take_match = hit && !abort_i && !start_i;

        new_frame.body = start_body_i;
        new_frame.stop = start_end_i;
        new_frame.cnt  = start_cnt_i;

        ctl        = '0;
        ctl.target = top.body;
        if (abort_i) begin
            ctl.pop = !empty;
        end else if (take_start) begin
            if (zero_cnt) begin
                ctl.redir  = 1'b1;
                ctl.target = start_end_i;
            end else if (full) begin
                ctl.ovf = 1'b1;
            end else begin
                ctl.push = 1'b1;
            end
        end else if (take_match) begin
            if (last) begin
                ctl.pop = 1'b1;
            end else begin
                ctl.dec   = 1'b1;
                ctl.redir = 1'b1;
            end
        end
    end

    assign redirect_o    = ctl.redir;
    assign redirect_pc_o = ctl.target;
    assign loop_active_o = !empty;
    assign overflow_o    = ctl.ovf;
endmodule

// File: rtl/hw_loop_ctrl_chk.sv
module hw_loop_ctrl_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [CW-1:0] start_cnt_i,
    input logic [AW-1:0] start_end_i,
    input logic          abort_i,
    input logic          redirect_o,
    input logic [AW-1:0] redirect_pc_o,
    input logic          loop_active_o,
    input logic          overflow_o,
    input logic [LW-1:0] level
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active_o && !start_i) |-> !redirect_o);

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i && start_cnt_i != '0 && !overflow_o)
            |=> level == LW'($past(level) + LW'(1)));

    assert_zero_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i && start_cnt_i == '0)
            |-> (redirect_o && redirect_pc_o == start_end_i));

    assert_zero_nopush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i && start_cnt_i == '0) |=> level == $past(level));

    assert_no_overflow_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> (level == $past(level) && level == LW'(DEPTH)));

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |-> !redirect_o);

    assert_abort_pops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && loop_active_o) |=> level == LW'($past(level) - LW'(1)));

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

bind hw_loop_ctrl hw_loop_ctrl_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .start_cnt_i   (start_cnt_i),
    .start_end_i   (start_end_i),
    .abort_i       (abort_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .loop_active_o (loop_active_o),
    .overflow_o    (overflow_o),
    .level         (level)
);

// File: tb/hw_loop_ctrl_test.sv
module hw_loop_ctrl_test;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DEPTH = 4;
    localparam int NV = 26;

    typedef struct packed {
        logic          st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] sa;
        logic [AW-1:0] ea;
        logic          fv;
        logic [AW-1:0] pc;
        logic          ab;
        logic          erd;
        logic [AW-1:0] erpc;
        logic          eact;
        logic          eovf;
        logic [7:0]    req;
    } vec_t;

    function automatic vec_t mk(logic st, int cnt, int sa, int ea, logic fv, int pc,
                                logic ab, logic erd, int erpc, logic eact, logic eovf,
                                int req);
        vec_t v;
        v.st = st; v.cnt = CW'(cnt); v.sa = AW'(sa); v.ea = AW'(ea);
        v.fv = fv; v.pc = AW'(pc); v.ab = ab; v.erd = erd; v.erpc = AW'(erpc);
        v.eact = eact; v.eovf = eovf; v.req = 8'(req);
        return v;
    endfunction

    // fields: start cnt body end | fvalid pc abort | exp redirect target active overflow | req
    localparam vec_t VEC [NV] = '{
        // single loop, count 3: R2, R3, R4
        mk(1, 3, 'h10, 'h13, 0, 0,    0, 0, 0,    0, 0, 2),
        mk(0, 0, 0, 0,       1, 'h10, 0, 0, 0,    1, 0, 2),
        mk(0, 0, 0, 0,       1, 'h12, 0, 1, 'h10, 1, 0, 3),
        mk(0, 0, 0, 0,       1, 'h12, 0, 1, 'h10, 1, 0, 3),
        mk(0, 0, 0, 0,       1, 'h12, 0, 0, 0,    1, 0, 4),
        mk(0, 0, 0, 0,       1, 'h13, 0, 0, 0,    0, 0, 4),
        // nested, outer 2 x inner 3: R5, R4
        mk(1, 2, 'h20, 'h30, 0, 0,    0, 0, 0,    0, 0, 5),
        mk(1, 3, 'h21, 'h25, 0, 0,    0, 0, 0,    1, 0, 5),
        mk(0, 0, 0, 0,       1, 'h24, 0, 1, 'h21, 1, 0, 5),
        mk(0, 0, 0, 0,       1, 'h24, 0, 1, 'h21, 1, 0, 5),
        mk(0, 0, 0, 0,       1, 'h24, 0, 0, 0,    1, 0, 5),
        mk(0, 0, 0, 0,       1, 'h2F, 0, 1, 'h20, 1, 0, 5),
        mk(1, 3, 'h21, 'h25, 0, 0,    0, 0, 0,    1, 0, 5),
        mk(0, 0, 0, 0,       1, 'h24, 0, 1, 'h21, 1, 0, 5),
        mk(0, 0, 0, 0,       1, 'h24, 0, 1, 'h21, 1, 0, 5),
        mk(0, 0, 0, 0,       1, 'h24, 0, 0, 0,    1, 0, 4),
        mk(0, 0, 0, 0,       1, 'h2F, 0, 0, 0,    1, 0, 4),
        mk(0, 0, 0, 0,       1, 'h30, 0, 0, 0,    0, 0, 4),
        // zero count: R6
        mk(1, 0, 'h40, 'h48, 0, 0,    0, 1, 'h48, 0, 0, 6),
        mk(0, 0, 0, 0,       1, 'h48, 0, 0, 0,    0, 0, 6),
        // fetch qualification: R9
        mk(1, 2, 'h50, 'h52, 0, 0,    0, 0, 0,    0, 0, 9),
        mk(0, 0, 0, 0,       0, 'h51, 0, 0, 0,    1, 0, 9),
        mk(0, 0, 0, 0,       1, 'h50, 0, 0, 0,    1, 0, 9),
        mk(0, 0, 0, 0,       1, 'h51, 0, 1, 'h50, 1, 0, 9),
        mk(0, 0, 0, 0,       1, 'h51, 0, 0, 0,    1, 0, 9),
        mk(0, 0, 0, 0,       1, 'h52, 0, 0, 0,    0, 0, 9)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] start_cnt_i = '0;
    logic [AW-1:0] start_body_i = '0;
    logic [AW-1:0] start_end_i = '0;
    logic          fetch_valid_i = 1'b0;
    logic [AW-1:0] fetch_pc_i = '0;
    logic          abort_i = 1'b0;
    logic          redirect_o;
    logic [AW-1:0] redirect_pc_o;
    logic          loop_active_o;
    logic          overflow_o;

    int applied = 0;
    int bad = 0;

    always #2 clk = ~clk;

    hw_loop_ctrl #(.DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_cnt_i   (start_cnt_i),
        .start_body_i  (start_body_i),
        .start_end_i   (start_end_i),
        .fetch_valid_i (fetch_valid_i),
        .fetch_pc_i    (fetch_pc_i),
        .abort_i       (abort_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .loop_active_o (loop_active_o),
        .overflow_o    (overflow_o)
    );

    task automatic apply(input vec_t v);
        @(negedge clk);
        start_i = v.st; start_cnt_i = v.cnt; start_body_i = v.sa; start_end_i = v.ea;
        fetch_valid_i = v.fv; fetch_pc_i = v.pc; abort_i = v.ab;
        #1;
        applied++;
        if (redirect_o !== v.erd || (v.erd && redirect_pc_o !== v.erpc) ||
            loop_active_o !== v.eact || overflow_o !== v.eovf) begin
            bad++;
            $display("FAIL R%0d vec %0d: rd=%0b pc=%h act=%0b ovf=%0b, expected rd=%0b pc=%h act=%0b ovf=%0b",
                     v.req, applied, redirect_o, redirect_pc_o, loop_active_o, overflow_o,
                     v.erd, v.erpc, v.eact, v.eovf);
        end
    endtask

    function automatic vec_t idle(logic eact, int req);
        return mk(0, 0, 0, 0, 0, 0, 0, 0, 0, eact, 0, req);
    endfunction

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state
        apply(idle(0, 1));
        @(negedge clk); rst_n = 1'b1;
        apply(mk(0, 0, 0, 0, 1, 'h12, 0, 0, 0, 0, 0, 1));

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R7: fill the stack, then one start too many
        for (int k = 0; k < DEPTH; k++)
            apply(mk(1, 5, 'h60 + k, 'h70 + k, 0, 0, 0, 0, 0, k != 0, 0, 7));
        apply(mk(1, 5, 'h68, 'h78, 0, 0, 0, 0, 0, 1, 1, 7));
        // R8: abort at the top level's last body address, no redirect
        apply(mk(0, 0, 0, 0, 1, 'h72, 1, 0, 0, 1, 0, 8));
        // R7: refused start left exactly DEPTH levels; innermost is now body 0x62
        apply(mk(0, 0, 0, 0, 1, 'h71, 0, 1, 'h62, 1, 0, 7));
        apply(mk(0, 0, 0, 0, 0, 0,    1, 0, 0,    1, 0, 8));
        apply(mk(0, 0, 0, 0, 0, 0,    1, 0, 0,    1, 0, 8));
        apply(mk(0, 0, 0, 0, 0, 0,    1, 0, 0,    1, 0, 8));
        apply(idle(0, 8));

        // R10: abort beats a simultaneous start
        apply(mk(1, 2, 'h80, 'h82, 0, 0, 0, 0, 0, 0, 0, 10));
        apply(mk(1, 3, 'h90, 'h94, 0, 0, 1, 0, 0, 1, 0, 10));
        apply(idle(0, 10));
        // R10: start beats a fetch match in the same cycle
        apply(mk(1, 2, 'h80, 'h82, 0, 0, 0, 0, 0, 0, 0, 10));
        apply(mk(1, 0, 'hA0, 'hA8, 1, 'h81, 0, 1, 'hA8, 1, 0, 10));
        apply(mk(0, 0, 0, 0, 1, 'h81, 0, 1, 'h80, 1, 0, 10));

        // R1: reset in mid-loop clears everything
        @(negedge clk); rst_n = 1'b0;
        apply(mk(0, 0, 0, 0, 1, 'h81, 0, 0, 0, 0, 0, 1));
        @(negedge clk); rst_n = 1'b1;
        apply(mk(0, 0, 0, 0, 1, 'h81, 0, 0, 0, 0, 0, 1));

        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule